// File: doc/BRIEF.md
# Serial Register Access Port

This block is the serial front end of a banked byte-wide register file in a companion power-management device. An external host drives chip select low and clocks exactly one 24-bit word into the port. The word carries a direction flag, a bank number and a register offset. On a write it also carries a data byte. On a read, the port answers inside the same word: the selected register's value comes back on the serial output in the last eight bit times.

The serial lines are brought into the block clock domain through a short synchroniser chain, and all edge detection happens on the system clock. On the inside, the port drives a plain register bus: a 16-bit address, write data, single-cycle write and read strobes, plus read data and a hit flag returned by the banks. The revision register lives inside the port. A read that no bank claims comes back as zero.

Top module: `spi_regport`

## Requirements
- R1: A frame is framed by `cs_n` low and uses SPI mode 0. Data is shifted most significant bit first: `mosi` is sampled on rising `sclk`, and `miso` changes after falling `sclk`. Frame bit 23 is the first bit on the wire.
- R2: When frame bit 23 is 0 (write), exactly one single-cycle `bus_wr` pulse follows the 24th rising edge. `bus_wdata` equals frame bits 7..0.
- R3: `bus_addr[12:8]` equals frame bits 22..18 (bank) and `bus_addr[7:0]` equals frame bits 17..10 (offset). `bus_addr[15:13]` is zero. Frame bits 9..8 have no effect on anything.
- R4: When frame bit 23 is 1 (read), exactly one single-cycle `bus_rd` pulse follows the 16th rising edge. No `bus_wr` is produced, and `bus_wr` and `bus_rd` are never high together.
- R5: For a read, response bits 7..0 carry the register value, most significant bit first. Response bits 23..8 are zero. A write frame returns all zeros.
- R6: Address 0x1080 is a read-only revision register that returns parameter `REV_CODE` (legal values 0x00, 0x10, 0x11), whatever the banks return. A write frame to 0x1080 produces no `bus_wr`.
- R7: A read for which `bus_hit` is low during the `bus_rd` cycle returns 0x00, whatever `bus_rdata` carries.
- R8: If `cs_n` rises before 24 bits have arrived, the frame is discarded with no `bus_wr`. The next frame is decoded from its own first bit.
- R9: While `rst_n` is low, `miso`, `bus_wr` and `bus_rd` are 0 from the next clock on, and `bus_addr` is 0. Outside a frame, `miso` stays low.
- R10: Clock edges after the 24th within one frame are ignored. They cause no second strobe and leave the written data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select framing one word |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial response to the host |
| bus_addr | output | 16 | Register address {3'b0, bank, offset} |
| bus_wdata | output | 8 | Write data byte |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_rd | output | 1 | Single-cycle read strobe |
| bus_rdata | input | 8 | Read data from the banks, valid in the `bus_rd` cycle |
| bus_hit | input | 1 | A bank claims `bus_addr` in the `bus_rd` cycle |

## Verification
The hardest case is the read turnaround. Read data must reach the output shifter in the short window between the 16th rising edge and the following falling edge, and that window only exists in the middle of a live frame. The stimulus runs complete read frames at a realistic clock ratio and compares the eight returned bits against values the bench itself wrote earlier. Truncated frames, over-long frames and writes aimed at the revision address are mixed in, so that a strobe appearing in the wrong place shows up both in the per-cycle strobe comparison and in later readbacks.

// File: rtl/spi_rp_pkg.sv
// Shared frame geometry and address helper for the serial register port.
// Assumes a fixed word: direction flag, bank, offset, two spare bits, data byte.
package spi_rp_pkg;
    localparam int unsigned FRAME_W = 24;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned BANK_W  = 5;
    localparam int unsigned OFS_W   = 8;
    localparam int unsigned ADDR_W  = 16;
    localparam int unsigned HDR_W   = FRAME_W - DATA_W;
    localparam int unsigned SEL_W   = BANK_W + OFS_W;
    localparam logic [ADDR_W-1:0] REV_ADDR = 16'h1080;

    // Turns {bank, offset} into the internal bus address (bank in upper byte).
    function automatic logic [ADDR_W-1:0] sel_to_addr(input logic [SEL_W-1:0] sel);
        return ADDR_W'(sel);
    endfunction
endpackage

// File: rtl/sync_chain.sv
// Multi-stage synchroniser for a bundle of slow asynchronous inputs.
// Assumes each input holds for several clk cycles; STAGES >= 1.
module sync_chain #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
// Receive and transmit shifters for one framed serial word (mode 0, MSB first).
// Assumes synchronised inputs; flags the header (16 bits) and the full word.
module frame_shifter
    import spi_rp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               cs_s,
    input  logic               mosi_s,
    input  logic               load,
    input  logic [DATA_W-1:0]  load_data,
    output logic [FRAME_W-1:0] rx_word,
    output logic               hdr_stb,
    output logic               frm_stb,
    output logic               miso
);
    localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
    localparam int unsigned PAD_W = FRAME_W - 1 - DATA_W;

    logic             sclk_q;
    logic [CNT_W-1:0] cnt;
    logic [FRAME_W-1:0] tx;
    logic             rise;
    logic             fall;

    assign rise = sclk_s & ~sclk_q & ~cs_s;
    assign fall = ~sclk_s & sclk_q & ~cs_s;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Collect incoming bits, stopping once a full word has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            cnt     <= '0;
            rx_word <= '0;
        end else if (rise && cnt != CNT_W'(FRAME_W)) begin
            rx_word <= {rx_word[FRAME_W-2:0], mosi_s};
            cnt     <= cnt + 1'b1;
        end
    end

    // Pulse once when the header and once when the whole word is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_stb <= 1'b0;
            frm_stb <= 1'b0;
        end else begin
            hdr_stb <= rise && cnt == CNT_W'(HDR_W - 1);
            frm_stb <= rise && cnt == CNT_W'(FRAME_W - 1);
        end
    end

    // Response shifter: zeros, with read data placed to leave on the next falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) tx <= '0;
        else if (load)      tx <= {1'b0, load_data, {PAD_W{1'b0}}};
        else if (fall)      tx <= {tx[FRAME_W-2:0], 1'b0};
    end

    assign miso = tx[FRAME_W-1];
endmodule

// File: rtl/reg_bus_ctl.sv
// Decodes a received word into register-bus strobes and picks the read response.
// Assumes hdr_stb and frm_stb never coincide; the revision register is local.
module reg_bus_ctl
    import spi_rp_pkg::*;
#(
    parameter logic [DATA_W-1:0] REV_CODE = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] rx_word,
    input  logic               hdr_stb,
    input  logic               frm_stb,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_hit,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_wr,
    output logic               bus_rd,
    output logic               load,
    output logic [DATA_W-1:0]  load_data
);
    logic [ADDR_W-1:0] hdr_addr;
    logic [ADDR_W-1:0] frm_addr;

    // At header time the word holds 16 bits; at frame time it holds all 24.
    assign hdr_addr = sel_to_addr(rx_word[HDR_W-2 -: SEL_W]);
    assign frm_addr = sel_to_addr(rx_word[FRAME_W-2 -: SEL_W]);

    // Issue read strobe after the header and write strobe after the full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
        end else begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b0;
            if (hdr_stb && rx_word[HDR_W-1]) begin
                bus_rd   <= 1'b1;
                bus_addr <= hdr_addr;
            end
            if (frm_stb && !rx_word[FRAME_W-1]) begin
                bus_wr    <= (frm_addr != REV_ADDR);
                bus_addr  <= frm_addr;
                bus_wdata <= rx_word[DATA_W-1:0];
            end
        end
    end

    // Select the byte to return: revision code, claimed bank data, or zero.
    always_comb begin
        load = bus_rd;
        if (bus_addr == REV_ADDR) load_data = REV_CODE;
        else if (bus_hit)         load_data = bus_rdata;
        else                      load_data = '0;
    end
endmodule

// File: rtl/spi_regport.sv
// Top of the serial register port: synchroniser, word shifter, bus decoder.
// Assumes clk runs at least ~8x faster than sclk so each half period spans the sync delay.
module spi_regport
    import spi_rp_pkg::*;
#(
    parameter logic [7:0]  REV_CODE    = 8'h10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        miso,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        bus_wr,
    output logic        bus_rd,
    input  logic [7:0]  bus_rdata,
    input  logic        bus_hit
);
    logic               sclk_s;
    logic               cs_s;
    logic               mosi_s;
    logic [FRAME_W-1:0] rx_word;
    logic               hdr_stb;
    logic               frm_stb;
    logic               load;
    logic [DATA_W-1:0]  load_data;

    sync_chain #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sclk, cs_n, mosi}),
        .dout  ({sclk_s, cs_s, mosi_s})
    );

    frame_shifter i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .cs_s      (cs_s),
        .mosi_s    (mosi_s),
        .load      (load),
        .load_data (load_data),
        .rx_word   (rx_word),
        .hdr_stb   (hdr_stb),
        .frm_stb   (frm_stb),
        .miso      (miso)
    );

    reg_bus_ctl #(
        .REV_CODE (REV_CODE)
    ) i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_word   (rx_word),
        .hdr_stb   (hdr_stb),
        .frm_stb   (frm_stb),
        .bus_rdata (bus_rdata),
        .bus_hit   (bus_hit),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .load      (load),
        .load_data (load_data)
    );
endmodule

// File: rtl/spi_regport_checker.sv
// Protocol properties of the serial register port, bound onto the top module.
// Assumes access to the synchronised chip-select level inside the top.
module spi_regport_checker
    import spi_rp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cs_s,
    input logic        miso,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_rd
);
    assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr);

    assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    assert_rev_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_addr != REV_ADDR);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!bus_wr && !bus_rd && !miso && bus_addr == 16'h0000));

    assert_idle_miso_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !miso);
endmodule

bind spi_regport spi_regport_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .miso     (miso),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd)
);

// File: tb/test_spi_regport.sv
`timescale 1ns/1ps
module test_spi_regport;
    localparam logic [7:0] REV = 8'h11;
    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic        bus_hit;

    int total = 0;
    int bad = 0;
    int wr_seen = 0;
    int rd_seen = 0;
    bit finished = 0;

    logic [7:0]  bank_mem [0:511];
    logic [23:0] exp_wr_q [$];
    logic [15:0] exp_rd_q [$];
    int          exp_m [int];

    always #2 clk = ~clk;

    spi_regport #(.REV_CODE(REV)) i_spi_regport (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_hit(bus_hit)
    );

    // Behavioural register banks: banks 2 and 3 exist, other banks drive junk.
    assign bus_hit   = (bus_addr[15:9] == 7'b0000001);
    assign bus_rdata = bus_hit ? bank_mem[bus_addr[8:0]] : 8'hEE;
    always @(posedge clk) if (bus_wr && bus_hit) bank_mem[bus_addr[8:0]] <= bus_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of bus strobes against the expected event queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_wr) begin
                wr_seen++;
                if (exp_wr_q.size() == 0) chk(0, "R2", "unexpected write", int'(bus_addr), 0);
                else begin
                    logic [23:0] e;
                    e = exp_wr_q.pop_front();
                    chk({bus_addr, bus_wdata} == e, "R3", "write addr/data",
                        int'({bus_addr, bus_wdata}), int'(e));
                end
            end
            if (bus_rd) begin
                rd_seen++;
                if (exp_rd_q.size() == 0) chk(0, "R4", "unexpected read", int'(bus_addr), 0);
                else begin
                    logic [15:0] e;
                    e = exp_rd_q.pop_front();
                    chk(bus_addr == e, "R3", "read addr", int'(bus_addr), int'(e));
                end
            end
        end
    end

    function automatic logic [23:0] mk(input bit rd, input logic [4:0] bank,
                                       input logic [7:0] ofs, input logic [7:0] d,
                                       input logic [1:0] pad);
        return {rd, bank, ofs, pad, d};
    endfunction

    // Mode 0 host: drive on falling edge, sample miso just before each rising edge.
    task automatic xfer(input logic [23:0] word, input int nbits, output logic [31:0] resp);
        resp = '0;
        @(negedge clk);
        cs_n = 1'b0;
        sclk = 1'b0;
        for (int k = 0; k < nbits; k++) begin
            mosi = (k < 24) ? word[23-k] : 1'b1;
            repeat (HP) @(negedge clk);
            resp = {resp[30:0], miso};
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (4 * HP) @(negedge clk);
    endtask

    function automatic logic [7:0] expect_rd(input logic [15:0] a);
        if (a == 16'h1080) return REV;
        if (a[15:9] == 7'b0000001 && exp_m.exists(int'(a))) return 8'(exp_m[int'(a)]);
        return 8'h00;
    endfunction

    task automatic do_write(input logic [4:0] bank, input logic [7:0] ofs,
                            input logic [7:0] d, input logic [1:0] pad);
        logic [31:0] r;
        logic [15:0] a;
        a = {3'b000, bank, ofs};
        if (a != 16'h1080) exp_wr_q.push_back({a, d});
        if (a[15:9] == 7'b0000001) exp_m[int'(a)] = int'(d);
        xfer(mk(1'b0, bank, ofs, d, pad), 24, r);
        chk(r[23:0] == 24'h0, "R5", "write response", int'(r[23:0]), 0);
    endtask

    task automatic do_read(input logic [4:0] bank, input logic [7:0] ofs, input string req);
        logic [31:0] r;
        logic [15:0] a;
        logic [7:0]  e;
        a = {3'b000, bank, ofs};
        e = expect_rd(a);
        exp_rd_q.push_back(a);
        xfer(mk(1'b1, bank, ofs, 8'h5A, 2'b11), 24, r);
        chk(r[23:0] == {16'h0, e}, req, "read response", int'(r[23:0]), int'({16'h0, e}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int w0;
        for (int i = 0; i < 512; i++) bank_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R9: quiet outputs during reset
        chk(miso == 1'b0 && bus_wr == 1'b0 && bus_rd == 1'b0, "R9", "reset strobes/miso",
            int'({miso, bus_wr, bus_rd}), 0);
        chk(bus_addr == 16'h0, "R9", "reset address", int'(bus_addr), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 R2 R3: basic writes, padding bits set on one of them
        do_write(5'd2, 8'h05, 8'hA5, 2'b00);
        do_write(5'd3, 8'hFF, 8'h3C, 2'b11);
        do_write(5'd2, 8'h00, 8'h81, 2'b10);
        // R4 R5: same-frame readback
        do_read(5'd2, 8'h05, "R5");
        do_read(5'd3, 8'hFF, "R5");
        do_read(5'd2, 8'h00, "R4");
        do_read(5'd3, 8'h10, "R1");
        // R6: revision read, then a write attempt that must not reach the bus
        do_read(5'h10, 8'h80, "R6");
        w0 = wr_seen;
        xfer(mk(1'b0, 5'h10, 8'h80, 8'h55, 2'b00), 24, r);
        chk(wr_seen == w0, "R6", "write strobes to revision", wr_seen - w0, 0);
        do_read(5'h10, 8'h80, "R6");
        // R7: unclaimed addresses read as zero despite junk on the bus
        do_read(5'd7, 8'h55, "R7");
        do_read(5'd31, 8'h80, "R7");
        // R8: truncated write, then truncated read, then a fresh frame
        w0 = wr_seen;
        xfer(mk(1'b0, 5'd2, 8'h05, 8'h11, 2'b00), 20, r);
        chk(wr_seen == w0, "R8", "write strobes after short frame", wr_seen - w0, 0);
        xfer(mk(1'b1, 5'd3, 8'h00, 8'h00, 2'b00), 10, r);
        do_read(5'd2, 8'h05, "R8");
        // R10: over-long frame yields one write with the first word's data
        w0 = wr_seen;
        exp_wr_q.push_back({16'h0207, 8'hC3});
        exp_m[16'h0207] = 8'hC3;
        xfer(mk(1'b0, 5'd2, 8'h07, 8'hC3, 2'b00), 28, r);
        chk(wr_seen == w0 + 1, "R10", "write strobes for long frame", wr_seen - w0, 1);
        do_read(5'd2, 8'h07, "R10");
        // R1: several distinct bit patterns round trip
        for (int i = 0; i < 4; i++) begin
            do_write(5'd3, 8'(8'h20 + i), 8'(8'h96 ^ (i * 8'h35)), 2'(i));
        end
        for (int i = 0; i < 4; i++) begin
            do_read(5'd3, 8'(8'h20 + i), "R1");
        end
        // R2 R4: every expected strobe was observed
        chk(exp_wr_q.size() == 0, "R2", "pending writes", exp_wr_q.size(), 0);
        chk(exp_rd_q.size() == 0, "R4", "pending reads", exp_rd_q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule